// File: doc/BRIEF.md
# Debug Bus Visibility Mirror

This block mirrors a chip's internal bus cycles onto the external bus pins so a logic analyser or debugger can watch on-chip transfers. The address, function-code, size and direction outputs always follow the internal bus, one clock behind. A small configuration register decides whether internal cycles are fully visible. When visibility is on, the data strobe and the data bus also follow internal cycles. When it is off, both stay quiet.

Mirrored cycles never raise the external address strobe. The data strobe carries the address timing instead, and this is how an observer tells an internal cycle apart from a real external access. For a mirrored write, data goes out from the first clock of the cycle. For a mirrored read, data goes out once the internal read data is marked valid. In both cases the data group is released one clock after the internal strobe ends.

Top module: `dbgvis_mirror`

## Requirements
- R1: While reset is asserted and in the first cycle after it, cfg_rdata is 00 and ext_ds, ext_strb_oe and ext_data_oe are 0.
- R2: A clock edge with cfg_we high loads cfg_wdata into the 2-bit enable field. The new value appears on cfg_rdata after that edge.
- R3: ext_addr, ext_fc, ext_size and ext_rw equal ib_addr, ib_fc, ib_size and ib_rw as sampled at the previous clock edge, whatever the enable field holds.
- R4: With the enable field at 00, the next clock holds ext_ds, ext_strb_oe and ext_data_oe at 0 and ext_data at all zeros.
- R5: With the enable field at any nonzero value (01, 10 or 11), ext_strb_oe is 1 and ext_ds equals ib_strb as sampled at the previous edge.
- R6: ext_as is 0 at all times.
- R7: When visibility is on and a write cycle is active (ib_strb=1, ib_rw=0), the next clock drives ext_data_oe to 1 and ext_data to ib_wdata.
- R8: When visibility is on and a read cycle is active (ib_rw=1), ext_data_oe stays 0 until ib_rd_valid is seen. From the next clock it is 1 and ext_data carries ib_rdata, and this holds for the rest of the cycle even after ib_rd_valid falls.
- R9: Once ib_strb falls on a driven cycle, ext_data_oe stays 1 for exactly one more clock with the data held, then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the enable field |
| cfg_wdata | input | 2 | Value to write into the enable field |
| cfg_rdata | output | 2 | Current enable field |
| ib_addr | input | AW | Internal bus address |
| ib_fc | input | 3 | Internal bus function code |
| ib_size | input | 2 | Internal bus transfer size |
| ib_rw | input | 1 | Internal direction, 1 = read |
| ib_strb | input | 1 | Internal cycle active |
| ib_rd_valid | input | 1 | Internal read data valid |
| ib_wdata | input | DW | Internal write data |
| ib_rdata | input | DW | Internal read data |
| ext_addr | output | AW | Mirrored address |
| ext_fc | output | 3 | Mirrored function code |
| ext_size | output | 2 | Mirrored size |
| ext_rw | output | 1 | Mirrored direction |
| ext_as | output | 1 | External address strobe, held low for mirrored cycles |
| ext_ds | output | 1 | External data strobe carrying the mirrored cycle timing |
| ext_strb_oe | output | 1 | Output enable for the strobe group |
| ext_data | output | DW | Mirrored data, zero while not driven |
| ext_data_oe | output | 1 | Output enable for the data group |

## Verification
The bench runs every enable value (00, 01, 10, 11) against write cycles and against read cycles whose valid arrives one clock late, each with several address and data patterns. Running 00 against the three nonzero values shows that only the data strobe and data group react to the enable field, while the attribute mirror stays the same. Running writes against late-valid reads shows apart data driven from the first clock and data held back until valid. The clock after the strobe falls, and the clock after that, confirm the one-cycle hold and the release.

// File: rtl/dbgvis_pkg.sv
package dbgvis_pkg;
  localparam int CFG_W  = 2;
  localparam int FC_W   = 3;
  localparam int SIZE_W = 2;

  typedef logic [CFG_W-1:0] cfg_t;

  // Any nonzero enable field turns full visibility on.
  function automatic logic show_enabled(input cfg_t cfg);
    return |cfg;
  endfunction

  // A cycle may drive data once it is a write, or a read with valid data.
  function automatic logic data_ready(input logic is_read, input logic rd_ok);
    return !is_read || rd_ok;
  endfunction
endpackage

// File: rtl/dbgvis_cfg_reg.sv
module dbgvis_cfg_reg
  import dbgvis_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  cfg_t wdata,
  output cfg_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/dbgvis_attr_mirror.sv
module dbgvis_attr_mirror
  import dbgvis_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     in_addr,
  input  logic [FC_W-1:0]   in_fc,
  input  logic [SIZE_W-1:0] in_size,
  input  logic              in_rw,
  output logic [AW-1:0]     out_addr,
  output logic [FC_W-1:0]   out_fc,
  output logic [SIZE_W-1:0] out_size,
  output logic              out_rw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr <= '0;
      out_fc   <= '0;
      out_size <= '0;
      out_rw   <= 1'b1;
    end else begin
      out_addr <= in_addr;
      out_fc   <= in_fc;
      out_size <= in_size;
      out_rw   <= in_rw;
    end
  end
endmodule

// File: rtl/dbgvis_data_ctl.sv
module dbgvis_data_ctl
  import dbgvis_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          strb,
  input  logic          is_read,
  input  logic          rd_valid,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rdata,
  output logic          ds,
  output logic          strb_oe,
  output logic [DW-1:0] data,
  output logic          data_oe,
  output logic          drv_now,
  output logic          drv_prev
);
  logic          rd_seen;
  logic          rd_ok;
  logic          hold_tail;
  logic [DW-1:0] data_q;
  logic          oe_q;

  assign rd_ok     = rd_valid || rd_seen;
  assign drv_now   = en && strb && data_ready(is_read, rd_ok);
  assign hold_tail = en && drv_prev && !strb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_seen  <= 1'b0;
      drv_prev <= 1'b0;
      data_q   <= '0;
      oe_q     <= 1'b0;
      ds       <= 1'b0;
      strb_oe  <= 1'b0;
    end else begin
      rd_seen  <= strb && is_read && rd_ok;
      drv_prev <= drv_now;
      oe_q     <= drv_now || hold_tail;
      ds       <= en && strb;
      strb_oe  <= en;
      if (drv_now) data_q <= is_read ? rdata : wdata;
    end
  end

  assign data    = oe_q ? data_q : '0;
  assign data_oe = oe_q;
endmodule

// File: rtl/dbgvis_mirror.sv
module dbgvis_mirror
  import dbgvis_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_wdata,
  output logic [1:0]        cfg_rdata,
  input  logic [AW-1:0]     ib_addr,
  input  logic [2:0]        ib_fc,
  input  logic [1:0]        ib_size,
  input  logic              ib_rw,
  input  logic              ib_strb,
  input  logic              ib_rd_valid,
  input  logic [DW-1:0]     ib_wdata,
  input  logic [DW-1:0]     ib_rdata,
  output logic [AW-1:0]     ext_addr,
  output logic [2:0]        ext_fc,
  output logic [1:0]        ext_size,
  output logic              ext_rw,
  output logic              ext_as,
  output logic              ext_ds,
  output logic              ext_strb_oe,
  output logic [DW-1:0]     ext_data,
  output logic              ext_data_oe
);
  cfg_t cfg_q;
  logic show_on;
  logic drv_now_w;
  logic drv_prev_w;

  dbgvis_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
  );

  assign cfg_rdata = cfg_q;
  assign show_on   = show_enabled(cfg_q);

  dbgvis_attr_mirror #(.AW(AW)) u_attr (
    .clk(clk), .rst_n(rst_n),
    .in_addr(ib_addr), .in_fc(ib_fc), .in_size(ib_size), .in_rw(ib_rw),
    .out_addr(ext_addr), .out_fc(ext_fc), .out_size(ext_size), .out_rw(ext_rw)
  );

  dbgvis_data_ctl #(.DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .en(show_on), .strb(ib_strb),
    .is_read(ib_rw), .rd_valid(ib_rd_valid),
    .wdata(ib_wdata), .rdata(ib_rdata),
    .ds(ext_ds), .strb_oe(ext_strb_oe),
    .data(ext_data), .data_oe(ext_data_oe),
    .drv_now(drv_now_w), .drv_prev(drv_prev_w)
  );

  // Mirrored cycles never present an address strobe.
  assign ext_as = 1'b0;
endmodule

// File: rtl/dbgvis_mirror_chk.sv
module dbgvis_mirror_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_rdata,
  input logic [AW-1:0] ib_addr,
  input logic          ib_strb,
  input logic          ib_rw,
  input logic [DW-1:0] ib_wdata,
  input logic [AW-1:0] ext_addr,
  input logic          ext_ds,
  input logic          ext_strb_oe,
  input logic          ext_data_oe,
  input logic [DW-1:0] ext_data,
  input logic          drv_prev_w
);
  p_reset_cfg_r1: assert property (@(posedge clk)
    !rst_n |=> (cfg_rdata == 2'b00));

  p_addr_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ext_addr == $past(ib_addr)));

  p_quiet_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata == 2'b00) |=> (!ext_ds && !ext_data_oe && !ext_strb_oe));

  p_ds_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata != 2'b00) |=> (ext_strb_oe && (ext_ds == $past(ib_strb))));

  p_write_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_rdata != 2'b00) && ib_strb && !ib_rw)
      |=> (ext_data_oe && (ext_data == $past(ib_wdata))));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ib_strb && !drv_prev_w) |=> !ext_data_oe);
endmodule

bind dbgvis_mirror dbgvis_mirror_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata),
  .ib_addr(ib_addr), .ib_strb(ib_strb), .ib_rw(ib_rw), .ib_wdata(ib_wdata),
  .ext_addr(ext_addr), .ext_ds(ext_ds), .ext_strb_oe(ext_strb_oe),
  .ext_data_oe(ext_data_oe), .ext_data(ext_data), .drv_prev_w(drv_prev_w)
);

// File: tb/dbgvis_mirror_bench.sv
module dbgvis_mirror_bench;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_wdata = '0;
  logic [1:0]    cfg_rdata;
  logic [AW-1:0] ib_addr = '0;
  logic [2:0]    ib_fc = '0;
  logic [1:0]    ib_size = '0;
  logic          ib_rw = 1'b1;
  logic          ib_strb = 1'b0;
  logic          ib_rd_valid = 1'b0;
  logic [DW-1:0] ib_wdata = '0;
  logic [DW-1:0] ib_rdata = '0;
  logic [AW-1:0] ext_addr;
  logic [2:0]    ext_fc;
  logic [1:0]    ext_size;
  logic          ext_rw, ext_as, ext_ds, ext_strb_oe, ext_data_oe;
  logic [DW-1:0] ext_data;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dbgvis_mirror #(.AW(AW), .DW(DW)) u_dbgvis_mirror (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // One full internal cycle: strobe on, optional late valid, strobe off, tail.
  task automatic one_cycle(input logic [1:0] cfg, input logic rd,
                           input logic [AW-1:0] a, input logic [DW-1:0] wd,
                           input logic [DW-1:0] rdv);
    logic en;
    logic [DW-1:0] want;
    en   = (cfg != 2'b00);
    want = rd ? rdv : wd;
    @(negedge clk);
    ib_strb = 1; ib_rw = rd; ib_addr = a; ib_fc = a[2:0]; ib_size = a[4:3];
    ib_wdata = wd; ib_rdata = rdv; ib_rd_valid = 0;
    @(negedge clk);
    chk("R3 addr", 64'(ext_addr), 64'(a));
    chk("R3 attr", 64'({ext_fc, ext_size, ext_rw}), 64'({a[2:0], a[4:3], rd}));
    chk("R6 as", 64'(ext_as), 64'(0));
    chk("R5/R4 ds", 64'(ext_ds), 64'(en));
    chk("R5/R4 strb_oe", 64'(ext_strb_oe), 64'(en));
    if (rd) begin
      chk("R8 oe before valid", 64'(ext_data_oe), 64'(0));
      chk("R8/R4 data before valid", 64'(ext_data), 64'(0));
      ib_rd_valid = 1;
    end else begin
      chk("R7/R4 oe", 64'(ext_data_oe), 64'(en));
      chk("R7/R4 data", 64'(ext_data), en ? 64'(wd) : 64'(0));
    end
    @(negedge clk);
    chk("R7/R8 oe", 64'(ext_data_oe), 64'(en));
    chk("R7/R8 data", 64'(ext_data), en ? 64'(want) : 64'(0));
    ib_rd_valid = 0;
    @(negedge clk);
    chk("R8 hold oe", 64'(ext_data_oe), 64'(en));
    chk("R8 hold data", 64'(ext_data), en ? 64'(want) : 64'(0));
    ib_strb = 0;
    @(negedge clk);
    chk("R9 ds low", 64'(ext_ds), 64'(0));
    chk("R9 tail oe", 64'(ext_data_oe), 64'(en));
    chk("R9 tail data", 64'(ext_data), en ? 64'(want) : 64'(0));
    @(negedge clk);
    chk("R9 release oe", 64'(ext_data_oe), 64'(0));
    chk("R9/R4 release data", 64'(ext_data), 64'(0));
  endtask

  initial begin
    #1;
    chk("R1 cfg in reset", 64'(cfg_rdata), 64'(0));
    chk("R1 oe in reset", 64'({ext_ds, ext_strb_oe, ext_data_oe}), 64'(0));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cfg after reset", 64'(cfg_rdata), 64'(0));
    chk("R1 oe after reset", 64'({ext_ds, ext_strb_oe, ext_data_oe}), 64'(0));
    chk("R6 as after reset", 64'(ext_as), 64'(0));
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      cfg_we = 1; cfg_wdata = 2'(c);
      @(negedge clk);
      cfg_we = 0; cfg_wdata = 2'(3 - c);
      chk("R2 readback", 64'(cfg_rdata), 64'(c));
      @(negedge clk);
      chk("R2 no write when we low", 64'(cfg_rdata), 64'(c));
      for (int rd = 0; rd < 2; rd++) begin
        for (int p = 0; p < 3; p++) begin
          logic [AW-1:0] a;
          logic [DW-1:0] wd, rv;
          a  = 32'h1000_0000 * (c + 1) + 32'h0101 * (p * 7 + rd + 1);
          wd = 32'hA5A5_0000 ^ (32'(c) << 8) ^ (32'(p) << 4) ^ 32'(rd);
          rv = ~wd + 32'(p);
          one_cycle(2'(c), rd[0], a, wd, rv);
        end
      end
    end
    summary();
  end

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule